// File: doc/BRIEF.md
# Programmable Six-Bit Tick Divider

This cell turns one of several source tick streams into a slower tick stream and a matching square wave. Every source is a strobe that is high for one cycle of the single system clock. The cell counts strobes of the chosen source and emits one output strobe for every N+1 of them, where N is a six-bit field in the control word. The output level flips on each output strobe, so it is a square wave at half the strobe rate.

One 32-bit control word sets up the cell. It is written through a write strobe and 32-bit data, and it can be read back at all times. A build-time parameter sets how many sources exist: one, four or eight. That count also decides where the source-select field sits in the word. A stop bit halts the cell. Stopping with a zero divisor field stores 63 instead, so a stopped word never holds a zero divisor. A new divisor or source written while the cell runs is held back until the current output period ends.

Top module: `tick_divider6`

## Requirements
- R1: With divisor field N (word bits 5:0, 0 to 63), one output strobe is produced for every N+1 strobes of the selected source. The output strobe is high for one cycle, starting the cycle after the source strobe that completes the period.
- R2: While the stop bit (word bit 8) is 1, `out_tick` stays 0 and `out_level` is 0 from the cycle after the stop takes effect, and source strobes are not counted.
- R3: With four sources, word bits 7:6 give the index of the selected source. Strobes on the other sources have no effect on the output.
- R4: With eight sources, word bits 14:12 give the index of the selected source. Strobes on the other sources have no effect on the output.
- R5: With one source, source 0 is always used, and word bits 7:6 and 14:12 read as 0.
- R6: A write of a word with bit 8 set and bits 5:0 all zero stores bits 5:0 as 63. A write with bit 8 set and a nonzero divisor stores that divisor unchanged.
- R7: A read returns the stored control word.
- R8: A divisor or source change written in the middle of an output period takes effect only after that period completes. The period in progress keeps the old ratio and the old source.
- R9: After the stop bit is cleared, counting restarts from zero. The first output strobe comes after a full N+1 source strobes, whatever was counted before the stop.
- R10: `out_level` flips on every output strobe. After reset, `out_level` is 0 and the word reads 0x13F (stop set, divisor 63, source 0).
- R11: Word bits outside the divisor field, the stop bit and the select field that exists for this build read as 0, and writes to them are ignored. The defined-bit mask is 0x713F for eight sources, 0x1FF for four and 0x13F for one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Stored control word |
| src_tick | input | NUM_SRC | One-cycle strobes, one per source |
| out_tick | output | 1 | Divided one-cycle strobe |
| out_level | output | 1 | Square wave that flips on every output strobe |

## Verification
The bench builds the cell three times, with NUM_SRC set to 8, 4 and 1. These three builds exercise every select-field position and every defined-bit mask. The eight-source build is used for the timing checks:
- the ratios 1, 2, 5 and 64;
- the stop and restart behaviour;
- the level toggling;
- a divisor and source change written in the middle of a period, checked one strobe at a time.

The four-source and one-source builds show that their own select field picks the source and that bits they do not own read back as zero.

// File: rtl/tdiv_pkg.sv
// Shared constants and field-layout helpers for the tick divider.
// Assumes the source count is one, four or eight.
package tdiv_pkg;
    localparam int REG_W     = 32;
    localparam int DIVF_W    = 6;
    localparam int STOP_BIT  = 8;
    localparam int RESET_DIV = (1 << DIVF_W) - 1;

    // Lowest bit of the source-select field for a given source count.
    function automatic int sel_lsb(input int n);
        return (n == 8) ? 12 : ((n == 4) ? 6 : 0);
    endfunction

    // Number of select bits actually stored in the word.
    function automatic int sel_bits(input int n);
        return (n == 8) ? 3 : ((n == 4) ? 2 : 0);
    endfunction

    // Width of select signals (at least one bit so vectors stay legal).
    function automatic int sel_w(input int n);
        return (sel_bits(n) > 0) ? sel_bits(n) : 1;
    endfunction

    // Mask of bits that exist in the control word.
    function automatic logic [REG_W-1:0] field_mask(input int n);
        logic [REG_W-1:0] m;
        m = REG_W'((1 << DIVF_W) - 1) | (REG_W'(1) << STOP_BIT);
        m = m | (REG_W'((1 << sel_bits(n)) - 1) << sel_lsb(n));
        return m;
    endfunction
endpackage

// File: rtl/tdiv_ctrl_reg.sv
// Control word storage. It keeps only the defined bits, forces a
// nonzero divisor on stop, and splits the word into configuration fields.
// Assumes one write port and no side effects on read.
module tdiv_ctrl_reg
    import tdiv_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int SEL_W  = sel_w(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic [DIVF_W-1:0] cfg_div,
    output logic [SEL_W-1:0]  cfg_sel,
    output logic              cfg_stop
);
    localparam logic [REG_W-1:0] MASK  = field_mask(NUM_SRC);
    localparam logic [REG_W-1:0] RST_V = (REG_W'(1) << STOP_BIT) | REG_W'(RESET_DIV);
    localparam int SLSB  = sel_lsb(NUM_SRC);
    localparam int SBITS = sel_bits(NUM_SRC);

    logic [REG_W-1:0] word_q;
    logic [REG_W-1:0] word_nx;

    // Next word: masked write data, with the stop-time divisor rule applied.
    always_comb begin
        word_nx = wr_data & MASK;
        if (word_nx[STOP_BIT] && (word_nx[DIVF_W-1:0] == '0))
            word_nx[DIVF_W-1:0] = '1;
    end

    // Word register with its reset value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= RST_V;
        else if (wr_en)
            word_q <= word_nx;
    end

    assign rd_data  = word_q;
    assign cfg_div  = word_q[DIVF_W-1:0];
    assign cfg_stop = word_q[STOP_BIT];

    generate
        if (SBITS > 0) begin : g_sel
            assign cfg_sel = word_q[SLSB +: SEL_W];
        end else begin : g_nosel
            assign cfg_sel = '0;
        end
    endgenerate

    AST_STOP_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        word_q[STOP_BIT] |-> (word_q[DIVF_W-1:0] != '0)); // R6

    AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~MASK) == '0); // R11
endmodule

// File: rtl/tdiv_src_mux.sv
// Picks the strobe of one source by index.
// Assumes the index is always in range (the select field is sized exactly).
module tdiv_src_mux
    import tdiv_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int SEL_W  = sel_w(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick
);
    generate
        if (NUM_SRC == 1) begin : g_single
            // The index is constant zero in this build.
            assign tick = src_tick[0] & ~(|sel);
        end else begin : g_multi
            assign tick = src_tick[sel];
        end
    endgenerate
endmodule

// File: rtl/tdiv_core.sv
// Divide counter. It counts selected strobes, emits the divided strobe and
// flips the level. Configuration is sampled only when the count is zero,
// that is at a period boundary or while stopped.
// Assumes the strobe input comes from the mux steered by eff_sel.
module tdiv_core
    import tdiv_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_stop,
    input  logic [DIVF_W-1:0] cfg_div,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              sel_tick,
    output logic [SEL_W-1:0]  eff_sel,
    output logic              out_tick,
    output logic              out_level
);
    logic [DIVF_W-1:0] cnt_q;
    logic [DIVF_W-1:0] act_div_q;
    logic [SEL_W-1:0]  act_sel_q;
    logic [DIVF_W-1:0] eff_div;
    logic              at_start;

    // At the start of a period the fresh configuration applies.
    assign at_start = (cnt_q == '0);
    assign eff_div  = at_start ? cfg_div : act_div_q;
    assign eff_sel  = at_start ? cfg_sel : act_sel_q;

    // Hold the configuration for the rest of a period once counting starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_div_q <= DIVF_W'(RESET_DIV);
            act_sel_q <= '0;
        end else begin
            act_div_q <= eff_div;
            act_sel_q <= eff_sel;
        end
    end

    // Count selected strobes and produce the divided strobe and level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            out_tick  <= 1'b0;
            out_level <= 1'b0;
        end else if (cfg_stop) begin
            cnt_q     <= '0;
            out_tick  <= 1'b0;
            out_level <= 1'b0;
        end else if (sel_tick) begin
            if (cnt_q == eff_div) begin
                cnt_q     <= '0;
                out_tick  <= 1'b1;
                out_level <= ~out_level;
            end else begin
                cnt_q    <= cnt_q + 1'b1;
                out_tick <= 1'b0;
            end
        end else begin
            out_tick <= 1'b0;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= act_div_q); // R1

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_stop |=> (!out_tick && !out_level)); // R2

    AST_LEVEL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick |-> (out_level != $past(out_level))); // R10

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> ($stable(act_div_q) && $stable(act_sel_q))); // R8
endmodule

// File: rtl/tick_divider6.sv
// Top level of the programmable tick divider: control word, source mux
// and divide counter. Everything runs on one clock; the sources are strobes
// that last one cycle. NUM_SRC must be 1, 4 or 8.
module tick_divider6
    import tdiv_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               out_tick,
    output logic               out_level
);
    localparam int SEL_W = sel_w(NUM_SRC);

    logic [DIVF_W-1:0] cfg_div;
    logic [SEL_W-1:0]  cfg_sel;
    logic              cfg_stop;
    logic [SEL_W-1:0]  eff_sel;
    logic              sel_tick;

    tdiv_ctrl_reg #(.NUM_SRC(NUM_SRC)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .cfg_div  (cfg_div),
        .cfg_sel  (cfg_sel),
        .cfg_stop (cfg_stop)
    );

    tdiv_src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
        .src_tick (src_tick),
        .sel      (eff_sel),
        .tick     (sel_tick)
    );

    tdiv_core #(.SEL_W(SEL_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_stop  (cfg_stop),
        .cfg_div   (cfg_div),
        .cfg_sel   (cfg_sel),
        .sel_tick  (sel_tick),
        .eff_sel   (eff_sel),
        .out_tick  (out_tick),
        .out_level (out_level)
    );
endmodule

// File: tb/test_tick_divider6.sv
// Directed bench: three builds (8, 4 and 1 sources), one task per scenario.
module test_tick_divider6;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] wr_data = '0;
    logic        we8 = 1'b0, we4 = 1'b0, we1 = 1'b0;
    logic [7:0]  src8 = '0;
    logic [3:0]  src4 = '0;
    logic [0:0]  src1 = '0;
    logic [31:0] rd8, rd4, rd1;
    logic        tk8, lv8, tk4, lv4, tk1, lv1;
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_divider6 #(.NUM_SRC(8)) i_tick_divider6 (
        .clk(clk), .rst_n(rst_n), .wr_en(we8), .wr_data(wr_data), .rd_data(rd8),
        .src_tick(src8), .out_tick(tk8), .out_level(lv8));
    tick_divider6 #(.NUM_SRC(4)) i_tick_divider6_four (
        .clk(clk), .rst_n(rst_n), .wr_en(we4), .wr_data(wr_data), .rd_data(rd4),
        .src_tick(src4), .out_tick(tk4), .out_level(lv4));
    tick_divider6 #(.NUM_SRC(1)) i_tick_divider6_one (
        .clk(clk), .rst_n(rst_n), .wr_en(we1), .wr_data(wr_data), .rd_data(rd1),
        .src_tick(src1), .out_tick(tk1), .out_level(lv1));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr8(input logic [31:0] d);
        wr_data = d; we8 = 1'b1; @(negedge clk); we8 = 1'b0;
    endtask
    task automatic wr4(input logic [31:0] d);
        wr_data = d; we4 = 1'b1; @(negedge clk); we4 = 1'b0;
    endtask
    task automatic wr1(input logic [31:0] d);
        wr_data = d; we1 = 1'b1; @(negedge clk); we1 = 1'b0;
    endtask
    task automatic pulse8(input int k, output logic o);
        src8[k] = 1'b1; @(negedge clk); o = tk8; src8 = '0;
    endtask
    task automatic pulse4(input int k, output logic o);
        src4[k] = 1'b1; @(negedge clk); o = tk4; src4 = '0;
    endtask
    task automatic pulse1(output logic o);
        src1[0] = 1'b1; @(negedge clk); o = tk1; src1 = '0;
    endtask
    // Stop, then run with divisor n and source s on the eight-source build.
    task automatic start8(input int n, input int s);
        wr8(32'h100 | (32'(s) << 12) | 32'(n));
        wr8((32'(s) << 12) | 32'(n));
    endtask

    task automatic t_reset;
        chk("R10 reset word 8", rd8, 32'h13F);
        chk("R10 reset word 4", rd4, 32'h13F);
        chk("R10 reset word 1", rd1, 32'h13F);
        chk("R10 reset level", {31'b0, lv8}, 0);
        chk("R2 reset tick", {31'b0, tk8}, 0);
    endtask

    task automatic t_mask;
        wr8(32'hFFFF_FFFF); chk("R11 R4 R7 mask 8", rd8, 32'h713F);
        wr4(32'hFFFF_FFFF); chk("R11 R3 mask 4", rd4, 32'h1FF);
        wr1(32'hFFFF_FFFF); chk("R11 R5 mask 1", rd1, 32'h13F);
        wr1(32'h0000_70C0); chk("R5 no select field", rd1, 32'h0);
    endtask

    task automatic t_stop_force;
        wr8(32'h100); chk("R6 zero divisor forced", rd8, 32'h13F);
        wr8(32'h105); chk("R6 nonzero divisor kept", rd8, 32'h105);
        wr8(32'h2A);  chk("R7 readback", rd8, 32'h2A);
    endtask

    task automatic t_ratio;
        int divs[4] = '{0, 1, 4, 63};
        foreach (divs[i]) begin
            int n = 0;
            logic o = 1'b0;
            start8(divs[i], 0);
            while (!o && n < 80) begin
                pulse8(0, o);
                n++;
            end
            chk($sformatf("R1 ratio for field %0d", divs[i]), 32'(n), 32'(divs[i] + 1));
        end
    endtask

    task automatic t_stopped;
        logic o;
        int seen = 0;
        start8(0, 0);
        wr8(32'h100);
        for (int i = 0; i < 5; i++) begin
            pulse8(0, o);
            if (o) seen++;
        end
        chk("R2 no strobe while stopped", 32'(seen), 0);
        chk("R2 level low while stopped", {31'b0, lv8}, 0);
    endtask

    task automatic t_restart;
        logic o;
        int seen = 0;
        start8(3, 0);
        pulse8(0, o); pulse8(0, o);
        wr8(32'h103);
        wr8(32'h003);
        for (int i = 0; i < 3; i++) begin
            pulse8(0, o);
            if (o) seen++;
        end
        chk("R9 no early strobe after restart", 32'(seen), 0);
        pulse8(0, o);
        chk("R9 strobe after full period", {31'b0, o}, 1);
    endtask

    task automatic t_level;
        logic o;
        start8(0, 0);
        chk("R10 level low at start", {31'b0, lv8}, 0);
        pulse8(0, o); chk("R10 level after strobe 1", {31'b0, lv8}, 1);
        pulse8(0, o); chk("R10 level after strobe 2", {31'b0, lv8}, 0);
        pulse8(0, o); chk("R10 level after strobe 3", {31'b0, lv8}, 1);
    endtask

    task automatic t_boundary;
        logic o;
        start8(2, 0);
        pulse8(0, o); chk("R8 first count", {31'b0, o}, 0);
        wr8(32'h0000_3000);
        pulse8(3, o); chk("R8 new source not yet used", {31'b0, o}, 0);
        pulse8(0, o); chk("R8 old ratio held", {31'b0, o}, 0);
        pulse8(0, o); chk("R8 old period completes", {31'b0, o}, 1);
        pulse8(0, o); chk("R8 old source dropped", {31'b0, o}, 0);
        pulse8(3, o); chk("R8 new source and ratio", {31'b0, o}, 1);
    endtask

    task automatic t_select;
        logic o;
        start8(0, 5);
        pulse8(2, o); chk("R4 other source ignored", {31'b0, o}, 0);
        pulse8(5, o); chk("R4 selected source 5", {31'b0, o}, 1);
        wr4(32'h0000_0080);
        pulse4(1, o); chk("R3 other source ignored", {31'b0, o}, 0);
        pulse4(2, o); chk("R3 selected source 2", {31'b0, o}, 1);
        wr1(32'h0);
        pulse1(o); chk("R5 single source used", {31'b0, o}, 1);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_stop_force();
        t_ratio();
        t_stopped();
        t_restart();
        t_level();
        t_boundary();
        t_select();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule